// File: doc/BRIEF.md
# Data Word Checksum Monitor

This block watches the data words of serial-bus messages at word level and keeps a per-message checksum over them. On a receive message it reports, word by word, whether the words seen so far sum to a clean result. When the end-of-message strobe arrives, it latches a validity flag for the whole message. On a transmit message it instead presents the word that, sent as the final data word, makes the message check clean at the far end. It also forwards each accepted word onto a registered word highway, and it flags the first (header) word of every message while that word sits on the highway.

The checksum is formed in a 16-bit accumulator. For each word, the accumulator is rotated left by one bit and the word is XORed in. The first word of a message restarts the accumulator from zero. A received message is good when the accumulator is zero after its last word. An active-low enable switches checking and generation on. While it is high, the block leaves the latched flag and the accumulator untouched, holds the running status high and offers a zero checksum word. The header indicator and highway keep working in either state.

Top module: `csum_monitor`

## Requirements
- R1: With checking enabled, each accepted word updates the accumulator as rotl1(acc) XOR word, where a word flagged first uses an accumulator of zero. During a transmit message the checksum word output equals rotl1(acc), so appending it drives the accumulator to zero.
- R2: With checking enabled on a receive message, running status is updated at the clock edge that accepts each word: 1 when the accumulator after that word is zero, 0 otherwise. It holds between words.
- R3: The validity flag (0 = good, 1 = bad) changes only at an end-of-message strobe of an enabled receive message. It then takes 0 if the accumulator (including any word accepted in that cycle) is zero, else 1.
- R4: A transmit message leaves the validity flag unchanged, and running status reads 1 in the cycle after any edge where the transmit qualifier is high.
- R5: The header indicator is 0 for exactly the cycle after a word flagged first is accepted, and 1 otherwise. This holds whatever the enable state.
- R6: While the enable input is 1, the checksum word output is 0, running status reads 1 after each edge, the validity flag holds, and the accumulator holds.
- R7: Asserting reset (active low, asynchronous) immediately gives valid flag 0, running status 1, header indicator 1, highway 0 and accumulator 0. Release takes effect two clock edges after the reset input rises.
- R8: When the last word and the end-of-message strobe fall in the same cycle, the latched verdict includes that word.
- R9: The word highway shows each accepted word from the edge after it is accepted and holds it until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en_n | input | 1 | Active-low checking/generation enable |
| msg_is_tx | input | 1 | 1 while the current message is a transmit message |
| word_vld | input | 1 | Data word strobe |
| word_first | input | 1 | Qualifies word_vld: this word is the first of its message |
| word_data | input | 16 | Data word value |
| msg_end | input | 1 | End-of-message strobe, one cycle |
| run_status | output | 1 | Running checksum status, 1 = clean so far |
| valid_n | output | 1 | Latched receive verdict, 0 = valid |
| hdr_n | output | 1 | Active-low header-word indicator |
| word_hwy | output | 16 | Registered copy of the last accepted word |
| csum_word | output | 16 | Checksum word to append on transmit |

## Verification
The last data word and the end-of-message strobe can arrive in the same cycle. In that case the latched verdict has to fold in a word that has not yet reached the accumulator register. The bench provokes this by asserting both strobes together on the closing word of a clean receive message whose previous flag was bad. It also does so in the generated-checksum round trip. The case is judged correct when the flag turns to 0 one edge later and running status reads 1 at the same moment.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  // one word-level event as seen on the input stream
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } ckm_evt_t;
endpackage

// File: rtl/ckm_rst_sync.sv
module ckm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ckm_accum.sv
module ckm_accum
  import ckm_pkg::*;
#(
  parameter int W   = 16,
  parameter int ROT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  ckm_evt_t     evt,
  input  logic [W-1:0] data,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_nxt,
  output logic [W-1:0] acc_rot
);
  localparam int R = ROT % W;

  logic [W-1:0] base;
  logic [W-1:0] base_rot;
  logic         upd;

  generate
    if (R == 0) begin : g_norot
      assign base_rot = base;
      assign acc_rot  = acc_q;
    end else begin : g_rot
      assign base_rot = {base[W-1-R:0], base[W-1:W-R]};
      assign acc_rot  = {acc_q[W-1-R:0], acc_q[W-1:W-R]};
    end
  endgenerate

  always_comb begin
    upd     = en && evt.vld;
    base    = evt.first ? '0 : acc_q;
    acc_nxt = upd ? (base_rot ^ data) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (upd) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/ckm_flags.sv
module ckm_flags
  import ckm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tx,
  input  ckm_evt_t evt,
  input  logic     acc_zero,
  output logic     run_status,
  output logic     valid_n
);
  logic run_q, run_d;
  logic vn_q, vn_d;
  logic vn_ce;

  always_comb begin
    if (!en || tx)   run_d = 1'b1;
    else if (evt.vld) run_d = acc_zero;
    else             run_d = run_q;
    vn_ce = en && !tx && evt.last;
    vn_d  = !acc_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vn_q <= 1'b0;
    else if (vn_ce) vn_q <= vn_d;
  end

  assign run_status = run_q;
  assign valid_n    = vn_q;
endmodule

// File: rtl/ckm_hdr.sv
module ckm_hdr
  import ckm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ckm_evt_t     evt,
  input  logic [W-1:0] data,
  output logic [W-1:0] hwy,
  output logic         hdr_n
);
  logic [W-1:0] hwy_q;
  logic         hdr_q, hdr_d;

  always_comb hdr_d = !(evt.vld && evt.first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hwy_q <= '0;
    else if (evt.vld) hwy_q <= data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= 1'b1;
    else        hdr_q <= hdr_d;
  end

  assign hwy   = hwy_q;
  assign hdr_n = hdr_q;
endmodule

// File: rtl/csum_monitor.sv
module csum_monitor
  import ckm_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ROT_STEP  = 1,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en_n,
  input  logic              msg_is_tx,
  input  logic              word_vld,
  input  logic              word_first,
  input  logic [WORD_W-1:0] word_data,
  input  logic              msg_end,
  output logic              run_status,
  output logic              valid_n,
  output logic              hdr_n,
  output logic [WORD_W-1:0] word_hwy,
  output logic [WORD_W-1:0] csum_word
);
  logic              rst_sync_n;
  logic              en;
  ckm_evt_t          evt;
  logic [WORD_W-1:0] acc_q, acc_nxt, acc_rot;

  assign en  = !chk_en_n;
  assign evt = '{vld: word_vld, first: word_first, last: msg_end};

  ckm_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ckm_accum #(.W(WORD_W), .ROT(ROT_STEP)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .evt(evt), .data(word_data),
    .acc_q(acc_q), .acc_nxt(acc_nxt), .acc_rot(acc_rot)
  );

  ckm_flags u_flg (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .tx(msg_is_tx), .evt(evt),
    .acc_zero(acc_nxt == '0), .run_status(run_status), .valid_n(valid_n)
  );

  ckm_hdr #(.W(WORD_W)) u_hdr (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .data(word_data),
    .hwy(word_hwy), .hdr_n(hdr_n)
  );

  // the word that zeroes the accumulator when sent last
  assign csum_word = (en && msg_is_tx) ? acc_rot : '0;
endmodule

// File: rtl/csum_monitor_chk.sv
module csum_monitor_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_en_n,
  input logic              msg_is_tx,
  input logic              word_vld,
  input logic              word_first,
  input logic [WORD_W-1:0] word_data,
  input logic              msg_end,
  input logic              run_status,
  input logic              valid_n,
  input logic              hdr_n,
  input logic [WORD_W-1:0] word_hwy,
  input logic [WORD_W-1:0] csum_word
);
  // R3
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_end |=> $stable(valid_n));

  // R4
  tx_keeps_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_is_tx |=> ($stable(valid_n) && run_status));

  // R5
  header_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word_first) |=> !hdr_n);

  // R5
  header_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> hdr_n);

  // R6
  off_no_csum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_n |-> (csum_word == '0));

  // R6
  off_run_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_n |=> (run_status && $stable(valid_n)));

  // R9
  highway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> (word_hwy == $past(word_data)));
endmodule

bind csum_monitor csum_monitor_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .chk_en_n(chk_en_n), .msg_is_tx(msg_is_tx),
  .word_vld(word_vld), .word_first(word_first), .word_data(word_data),
  .msg_end(msg_end), .run_status(run_status), .valid_n(valid_n),
  .hdr_n(hdr_n), .word_hwy(word_hwy), .csum_word(csum_word)
);

// File: tb/test_csum_monitor.sv
module test_csum_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic         tx;
    logic         en_n;
    logic         vld;
    logic         first;
    logic         last;
    logic [W-1:0] data;
    logic         e_run;
    logic         e_vn;
    logic         e_hdr;
    logic         chk_cs;
    logic [W-1:0] e_cs;
  } vec_t;

  // rows: good rx, bad rx, tx, good rx ending with word+end together, disabled
  localparam vec_t TBL [13] = '{
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0001, 1'b0,1'b0,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0002, 1'b1,1'b0,1'b1, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000, 1'b1,1'b0,1'b1, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0001, 1'b0,1'b0,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0003, 1'b0,1'b0,1'b1, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000, 1'b0,1'b1,1'b1, 1'b0,16'h0000},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,16'h1234, 1'b1,1'b1,1'b0, 1'b1,16'h2468},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h0000, 1'b1,1'b1,1'b1, 1'b1,16'h2468},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h8000, 1'b0,1'b1,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0001, 1'b1,1'b0,1'b1, 1'b0,16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,16'h0001, 1'b1,1'b0,1'b0, 1'b1,16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,16'h5555, 1'b1,1'b0,1'b0, 1'b1,16'h0000},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,16'h0007, 1'b1,1'b0,1'b1, 1'b0,16'h0000}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         chk_en_n, msg_is_tx, word_vld, word_first, msg_end;
  logic [W-1:0] word_data;
  logic         run_status, valid_n, hdr_n;
  logic [W-1:0] word_hwy, csum_word;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csum_monitor i_csum_monitor (
    .clk(clk), .rst_n(rst_n), .chk_en_n(chk_en_n), .msg_is_tx(msg_is_tx),
    .word_vld(word_vld), .word_first(word_first), .word_data(word_data),
    .msg_end(msg_end), .run_status(run_status), .valid_n(valid_n),
    .hdr_n(hdr_n), .word_hwy(word_hwy), .csum_word(csum_word)
  );

  function automatic logic [W-1:0] rotl1(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic tx, input logic en_n, input logic vld,
                       input logic first, input logic last, input logic [W-1:0] d);
    @(negedge clk);
    msg_is_tx = tx; chk_en_n = en_n; word_vld = vld;
    word_first = first; msg_end = last; word_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, chk_en_n, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] exp_acc;
    logic [W-1:0] gen_cs;
    rst_n = 1'b0; chk_en_n = 1'b0; msg_is_tx = 1'b1;
    word_vld = 1'b0; word_first = 1'b0; msg_end = 1'b0; word_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check("R7", "valid_n", {15'd0, valid_n}, 16'd0);
    check("R7", "run_status", {15'd0, run_status}, 16'd1);
    check("R7", "hdr_n", {15'd0, hdr_n}, 16'd1);
    check("R7", "word_hwy", word_hwy, 16'h0000);
    check("R7", "csum_word", csum_word, 16'h0000);
    @(negedge clk); rst_n = 1'b1; msg_is_tx = 1'b0;
    repeat (3) @(posedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 13; i++) begin
      drive(TBL[i].tx, TBL[i].en_n, TBL[i].vld, TBL[i].first, TBL[i].last, TBL[i].data);
      check("R2", $sformatf("row %0d run_status", i), {15'd0, run_status}, {15'd0, TBL[i].e_run});
      check("R3", $sformatf("row %0d valid_n", i), {15'd0, valid_n}, {15'd0, TBL[i].e_vn});
      check("R5", $sformatf("row %0d hdr_n", i), {15'd0, hdr_n}, {15'd0, TBL[i].e_hdr});
      if (TBL[i].vld)
        check("R9", $sformatf("row %0d word_hwy", i), word_hwy, TBL[i].data);
      if (TBL[i].chk_cs)
        check(TBL[i].en_n ? "R6" : "R1", $sformatf("row %0d csum_word", i), csum_word, TBL[i].e_cs);
    end
    idle();

    // R1 round trip: generate on transmit, then verify on receive
    exp_acc = 16'h00F0;
    exp_acc = rotl1(exp_acc) ^ 16'h0F00;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00F0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0F00);
    gen_cs = csum_word;
    check("R1", "generated checksum", gen_cs, rotl1(exp_acc));
    check("R1", "generated checksum literal", gen_cs, 16'h1DC0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    check("R4", "tx end keeps valid_n", {15'd0, valid_n}, 16'd0);
    // make verdict bad first, so the round trip must flip it back
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0004);
    check("R3", "single bad word", {15'd0, valid_n}, 16'd1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00F0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0F00);
    check("R2", "mid message run_status", {15'd0, run_status}, 16'd0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, gen_cs);
    check("R8", "round trip valid_n", {15'd0, valid_n}, 16'd0);
    check("R8", "round trip run_status", {15'd0, run_status}, 16'd1);

    // R7 asynchronous reset from a bad verdict
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0009);
    check("R3", "bad before reset", {15'd0, valid_n}, 16'd1);
    @(negedge clk); word_vld = 1'b0; msg_end = 1'b0; rst_n = 1'b0;
    #1;
    check("R7", "async valid_n", {15'd0, valid_n}, 16'd0);
    check("R7", "async run_status", {15'd0, run_status}, 16'd1);
    check("R7", "async word_hwy", word_hwy, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R7 release: still held after the first edge
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0003);
    check("R7", "held during release", word_hwy, 16'h0000);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0003);
    check("R7", "live after release", word_hwy, 16'h0003);
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule